// File: doc/BRIEF.md
# Palette Attribute Controller

This block holds the attribute registers of a legacy-style display pipeline and turns every 4-bit pixel code into an 8-bit colour index. A host reaches all of its registers through one byte-wide write port. An internal phase bit decides whether a write lands in the index register or in the register that the index selects. A strobe on the status-read input puts that phase bit back to the index state. Software uses this strobe to resynchronise before any access sequence.

Twenty-one data registers sit behind the index:
- sixteen palette entries at 0x00 to 0x0F;
- a mode register at 0x10;
- a border (overscan) colour at 0x11;
- plane-enable and panning bytes at 0x12 and 0x13, stored only;
- a colour-page register at 0x14.

Bit 5 of the index acts as a video-enable switch. While it is clear, every pixel is replaced by the border colour. The register that the index selects can be read back on a separate read-data output, and the index itself is visible on its own output.

Top module: `attr_ctrl`

## Requirements
- R1: After reset the phase bit is in the index state, the index reads 0x00 (video off), all 21 registers hold zero, and `rd_data` and `pix_out` are zero.
- R2: A cycle with `stat_rd` high returns the phase bit to the index state. A write in that same cycle is discarded.
- R3: After a status strobe, the first write loads the index and the next write loads the selected data register. Later writes keep alternating between index and data.
- R4: Pulses on `data_rd` never change the phase bit. `rd_data` shows the register selected by index bits 4:0, one cycle after any change of index or register contents.
- R5: `idx_out` returns the stored index bits 5:0, with bits 7:6 reading zero. Index bits 7:6 are not stored.
- R6: When index bits 4:0 are 0x15 to 0x1F, a data write changes no register, and `rd_data` reads zero.
- R7: While index bit 5 is clear, `pix_out` equals the border register at 0x11.
- R8: While video is on and mode bit 7 (register 0x10) is clear, `pix_out` = {page[3:2], palette[pix_in][5:0]}. Here page is register 0x14.
- R9: While video is on and mode bit 7 is set, `pix_out` = {page[3:2], page[1:0], palette[pix_in][3:0]}.
- R10: `pix_out` is registered. It reflects `pix_in` and the register state one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe for the shared index/data port |
| wr_data | input | 8 | Host write byte |
| stat_rd | input | 1 | Status-read strobe; returns the phase bit to the index state |
| data_rd | input | 1 | Read-data strobe; has no side effect |
| idx_out | output | 8 | Current index value, including the video-enable bit |
| rd_data | output | 8 | Contents of the selected register, registered |
| pix_in | input | 4 | Pixel code |
| pix_out | output | 8 | Colour index, registered |

## Verification
Some properties are checked on every cycle:
- a status strobe leaves the phase bit in the index state;
- a write flips the phase bit, and a read-data pulse does not;
- an out-of-range index reads back zero;
- the border colour replaces pixels while video is off;
- the top two output bits follow the page register while video is on.

Only the bench scenarios can show the rest. That covers which register a given write sequence actually reaches, a write dropped by a simultaneous strobe, the exact bit merging of the two paging modes, and the fact that writes to missing indices leave all 21 registers intact.

// File: rtl/attr_pkg.sv
package attr_pkg;
  typedef enum logic {PH_INDEX = 1'b0, PH_DATA = 1'b1} phase_e;

  // register slots whose contents feed the pixel path
  localparam int SLOT_MODE   = 16;
  localparam int SLOT_BORDER = 17;
  localparam int SLOT_PAGE   = 20;

  // bit positions inside the mode and page registers
  localparam int MODE_PAGING_BIT = 7;
endpackage

// File: rtl/attr_seq.sv
module attr_seq
  import attr_pkg::*;
#(
  parameter int IW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          stat_rd,
  input  logic          data_rd,
  output logic [IW-1:0] idx_q,
  output logic          data_we,
  output phase_e        phase
);
  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_INDEX;
      idx_q <= '0;
    end else if (stat_rd) begin
      phase <= PH_INDEX;
    end else if (wr_en) begin
      if (phase == PH_INDEX) begin
        idx_q <= wr_data[IW-1:0];
        phase <= PH_DATA;
      end else begin
        phase <= PH_INDEX;
      end
    end
  end

  assign data_we = wr_en && !stat_rd && (phase == PH_DATA);

  // R2
  strobe_to_index_chk: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> phase == PH_INDEX);

  // R3
  write_toggles_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !stat_rd) |=> phase != $past(phase));

  // R4
  read_keeps_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (data_rd && !wr_en && !stat_rd) |=> $stable(phase));
endmodule

// File: rtl/attr_regs.sv
module attr_regs
  import attr_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 21,
  parameter int PIXW = 4,
  parameter int AW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [AW-1:0]   sel,
  input  logic [DW-1:0]   wdata,
  input  logic [PIXW-1:0] pix_code,
  output logic [DW-1:0]   rd_data,
  output logic [DW-1:0]   pal_val,
  output logic [DW-1:0]   mode_val,
  output logic [DW-1:0]   border_val,
  output logic [DW-1:0]   page_val
);
  localparam logic [AW-1:0] LAST = AW'(NREG - 1);

  logic [DW-1:0] regs [NREG];
  logic          in_range;
  logic [AW-1:0] safe_sel;

  assign in_range = (sel <= LAST);
  assign safe_sel = in_range ? sel : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && in_range) begin
      regs[safe_sel] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= in_range ? regs[safe_sel] : '0;
  end

  assign pal_val    = regs[AW'(pix_code)];
  assign mode_val   = regs[SLOT_MODE];
  assign border_val = regs[SLOT_BORDER];
  assign page_val   = regs[SLOT_PAGE];

  // R6
  empty_slot_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !in_range |=> rd_data == '0);

  // R6
  empty_slot_write_chk: assert property (@(posedge clk) disable iff (rst)
    (we && !in_range) |=> $stable(page_val) && $stable(border_val) && $stable(mode_val));
endmodule

// File: rtl/attr_pix.sv
module attr_pix
  import attr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          video_on,
  input  logic [DW-1:0] pal_val,
  input  logic [DW-1:0] mode_val,
  input  logic [DW-1:0] border_val,
  input  logic [DW-1:0] page_val,
  output logic [DW-1:0] pix_out
);
  logic [DW-1:0] mixed;

  always_comb begin
    mixed = pal_val;
    mixed[DW-1:DW-2] = page_val[3:2];
    if (mode_val[MODE_PAGING_BIT])
      mixed[DW-3:DW-4] = page_val[1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)           pix_out <= '0;
    else if (video_on) pix_out <= mixed;
    else               pix_out <= border_val;
  end

  // R7
  blank_shows_border_chk: assert property (@(posedge clk) disable iff (rst)
    !video_on |=> pix_out == $past(border_val));

  // R8
  page_high_bits_chk: assert property (@(posedge clk) disable iff (rst)
    video_on |=> pix_out[DW-1:DW-2] == $past(page_val[3:2]));
endmodule

// File: rtl/attr_ctrl.sv
module attr_ctrl
  import attr_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 21,
  parameter int PIXW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  input  logic            stat_rd,
  input  logic            data_rd,
  output logic [DW-1:0]   idx_out,
  output logic [DW-1:0]   rd_data,
  input  logic [PIXW-1:0] pix_in,
  output logic [DW-1:0]   pix_out
);
  localparam int AW = $clog2(NREG);
  localparam int IW = AW + 1;

  logic [IW-1:0] idx_q;
  logic          data_we;
  phase_e        phase;
  logic [DW-1:0] pal_val, mode_val, border_val, page_val;

  attr_seq #(.IW(IW), .DW(DW)) u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .stat_rd(stat_rd), .data_rd(data_rd),
    .idx_q(idx_q), .data_we(data_we), .phase(phase)
  );

  attr_regs #(.DW(DW), .NREG(NREG), .PIXW(PIXW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .we(data_we), .sel(idx_q[AW-1:0]),
    .wdata(wr_data), .pix_code(pix_in), .rd_data(rd_data),
    .pal_val(pal_val), .mode_val(mode_val),
    .border_val(border_val), .page_val(page_val)
  );

  attr_pix #(.DW(DW)) u_pix (
    .clk(clk), .rst(rst), .video_on(idx_q[IW-1]),
    .pal_val(pal_val), .mode_val(mode_val),
    .border_val(border_val), .page_val(page_val), .pix_out(pix_out)
  );

  assign idx_out = DW'(idx_q);

  // R1
  reset_phase_chk: assert property (@(posedge clk)
    rst |=> phase == PH_INDEX && idx_out == '0 && pix_out == '0);
endmodule

// File: tb/test_attr_ctrl.sv
module test_attr_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       stat_rd = 1'b0;
  logic       data_rd = 1'b0;
  logic [3:0] pix_in = '0;
  logic [7:0] idx_out, rd_data, pix_out;

  attr_ctrl i_attr_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .stat_rd(stat_rd), .data_rd(data_rd), .idx_out(idx_out),
    .rd_data(rd_data), .pix_in(pix_in), .pix_out(pix_out)
  );

  always #5 clk = ~clk;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [7:0] m_regs [0:20];
  logic [5:0] m_idx = '0;
  bit         m_data = 1'b0;

  function automatic logic [7:0] exp_rd();
    return (m_idx[4:0] <= 5'd20) ? m_regs[m_idx[4:0]] : 8'h00;
  endfunction

  function automatic logic [7:0] exp_pix(input logic [3:0] p);
    logic [7:0] pal, pg;
    if (!m_idx[5]) return m_regs[17];
    pal = m_regs[p];
    pg  = m_regs[20];
    if (m_regs[16][7]) return {pg[3:2], pg[1:0], pal[3:0]};
    return {pg[3:2], pal[5:0]};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    if (!m_data) begin
      m_idx = v[5:0]; m_data = 1'b1;
    end else begin
      if (m_idx[4:0] <= 5'd20) m_regs[m_idx[4:0]] = v;
      m_data = 1'b0;
    end
  endtask

  task automatic strobe(input bit with_wr, input logic [7:0] v);
    @(negedge clk);
    stat_rd = 1'b1; wr_en = with_wr; wr_data = v;
    @(negedge clk);
    stat_rd = 1'b0; wr_en = 1'b0;
    m_data = 1'b0;
  endtask

  task automatic check_all(input string req);
    @(negedge clk);
    chk({req, " R5 idx"}, idx_out, {2'b00, m_idx});
    chk({req, " R4 rd"}, rd_data, exp_rd());
    chk({req, " pix"}, pix_out, exp_pix(pix_in));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] old;
    for (int i = 0; i <= 20; i++) m_regs[i] = 8'h00;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_all("R1 reset");

    // R3: alternating index/data after strobe
    strobe(1'b0, 8'h00);
    bus_wr(8'h23); bus_wr(8'h44);
    check_all("R3 first pair");
    bus_wr(8'h25); bus_wr(8'h66);
    check_all("R3 second pair");
    chk("R3 reg5", rd_data, 8'h66);

    // R4: data_rd pulses do not toggle the phase
    strobe(1'b0, 8'h00);
    bus_wr(8'h23);
    @(negedge clk); data_rd = 1'b1;
    repeat (3) @(negedge clk);
    data_rd = 1'b0;
    bus_wr(8'h77);
    check_all("R4 read no toggle");
    chk("R4 reg3", rd_data, 8'h77);

    // R2: strobe wins over a simultaneous write
    bus_wr(8'h2A);
    strobe(1'b1, 8'h11);
    bus_wr(8'h26);
    check_all("R2 strobe priority");
    chk("R2 idx", idx_out, 8'h26);

    // R6: empty indices
    strobe(1'b0, 8'h00);
    bus_wr(8'h37); bus_wr(8'hFF);
    check_all("R6 empty slot");
    chk("R6 zero", rd_data, 8'h00);
    for (int i = 0; i <= 20; i++) begin
      strobe(1'b0, 8'h00);
      bus_wr(8'h20 | 8'(i));
      check_all("R6 regs intact");
    end

    // R8/R9/R7: pixel mapping
    strobe(1'b0, 8'h00);
    bus_wr(8'h29); bus_wr(8'hE5);
    bus_wr(8'h30); bus_wr(8'h08);
    bus_wr(8'h34); bus_wr(8'h0B);
    bus_wr(8'h31); bus_wr(8'h5C);
    pix_in = 4'd9;
    check_all("R8 mode clear");
    chk("R8 value", pix_out, 8'hA5);
    bus_wr(8'h30); bus_wr(8'h88);
    check_all("R9 mode set");
    chk("R9 value", pix_out, 8'hB5);
    bus_wr(8'h11);
    check_all("R7 blanked");
    chk("R7 border", pix_out, 8'h5C);
    bus_wr(8'h5C);
    bus_wr(8'h20);
    check_all("R7 restored");

    // R10: one-edge pixel latency
    old = pix_out;
    @(negedge clk);
    pix_in = 4'd2;
    #1 chk("R10 hold", pix_out, old);
    @(negedge clk);
    chk("R10 update", pix_out, exp_pix(4'd2));

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      op = $urandom_range(0, 9);
      pix_in = 4'($urandom_range(0, 15));
      if (op == 0) strobe(1'b0, 8'h00);
      else if (op == 1) begin
        @(negedge clk); data_rd = 1'b1; @(negedge clk); data_rd = 1'b0;
      end else if (!m_data)
        bus_wr((($urandom_range(0, 3) != 0) ? 8'h20 : 8'h00) | 8'($urandom_range(0, 31)));
      else
        bus_wr(8'($urandom_range(0, 255)));
      check_all("R3 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule